// File: doc/BRIEF.md
# Event-Driven PI Tuning-Word Controller

This block is a proportional-integral loop filter built from integer arithmetic. It turns a stream of signed error samples into a signed tuning word for a digitally trimmed oscillator. A sample counts only when its valid strobe is high. On that cycle the block multiplies the error by a programmable proportional gain and adds the error times a programmable integral gain to a wide, persistent accumulator. It then sums these with a programmable base word and clips the result to a symmetric window of plus or minus a programmable limit.

The new word is registered. It appears one cycle after the error strobe, together with a one-cycle update pulse that a downstream writer can use to start a transfer to the oscillator. Between samples the word holds its value. Before the first sample after reset, the output shows the base word clipped to the window. The nominal limit for the target oscillator is 8161512.

Top module: `pi_tune_ctrl`

## Requirements
- R1: While reset is active and until the first accepted sample, `upd_o` is low, the accumulator is zero, and `tune_o` equals `base_i` clipped to [-`lim_i`, +`lim_i`].
- R2: `upd_o` is high for exactly the cycle that follows each cycle with `err_vld_i` high, and it is low in every other cycle.
- R3: In the cycle `upd_o` is high, `tune_o` equals clip(`base_i` + `err_i`·`kp_i` + A), where A is the accumulator value after this sample has been added. `err_i`, `kp_i`, `base_i` and `lim_i` are the values sampled with the strobe.
- R4: Each accepted sample adds `err_i`·`ki_i` to the accumulator. The accumulator holds its value across samples and is never cleared except by reset.
- R5: While `err_vld_i` is low, changes on `err_i`, `kp_i`, `ki_i` and `base_i` leave `tune_o` and the accumulator unchanged.
- R6: A sum above +`lim_i` produces exactly +`lim_i`.
- R7: A sum below -`lim_i` produces exactly -`lim_i`.
- R8: A sum equal to +`lim_i` or -`lim_i` passes through unchanged.
- R9: `err_i`, `kp_i`, `ki_i` and `base_i` are two's-complement signed, so negative gains invert the correction.
- R10: The accumulator keeps integrating while the output is clipped, so the output stays clipped until the accumulator has unwound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_i | input | ERR_W | Signed error sample |
| err_vld_i | input | 1 | Error sample strobe |
| kp_i | input | GAIN_W | Signed proportional gain |
| ki_i | input | GAIN_W | Signed integral gain |
| base_i | input | WORD_W | Signed base tuning word |
| lim_i | input | WORD_W-1 | Unsigned magnitude of the clip window |
| tune_o | output | WORD_W | Signed tuning word |
| upd_o | output | 1 | One-cycle pulse with each new tuning word |

## Verification
The bench uses the default widths: 16-bit errors and gains, a 24-bit word and a 48-bit accumulator. With these widths a full-scale error times a full-scale gain, the nominal limit of 8161512 and a 24-bit base all fit, so both clip edges can be driven by one large product. Small limits such as 100 and 500 make the exact-boundary and windup cases reachable within a few samples. Extreme errors (-32768 and +32767) and negative gains exercise sign handling in both multipliers.

// File: rtl/pi_tune_pkg.sv
package pi_tune_pkg;
  localparam int DEF_ERR_W  = 16;
  localparam int DEF_GAIN_W = 16;
  localparam int DEF_WORD_W = 24;
  localparam int DEF_ACC_W  = 48;
  localparam int NOMINAL_LIMIT = 8161512;
endpackage

// File: rtl/pi_rst_sync.sv
module pi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pi_gain_mul.sv
module pi_gain_mul #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W
) (
  input  logic signed [A_W-1:0] a_i,
  input  logic signed [B_W-1:0] b_i,
  output logic signed [P_W-1:0] p_o
);
  logic signed [P_W-1:0] a_ext;
  logic signed [P_W-1:0] b_ext;

  always_comb begin
    a_ext = P_W'(a_i);
    b_ext = P_W'(b_i);
    p_o   = a_ext * b_ext;
  end
endmodule

// File: rtl/pi_accum.sv
module pi_accum #(
  parameter int ACC_W = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] inc_i,
  output logic signed [ACC_W-1:0] acc_nx_o
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;

  always_comb begin
    acc_nx_o = acc_q + inc_i;
    acc_d    = en_i ? acc_nx_o : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/pi_clip.sv
module pi_clip #(
  parameter int IN_W  = 50,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  val_i,
  input  logic        [OUT_W-2:0] lim_i,
  output logic signed [OUT_W-1:0] val_o
);
  logic signed [IN_W-1:0] hi;
  logic signed [IN_W-1:0] lo;
  logic signed [IN_W-1:0] sel;

  always_comb begin
    hi = $signed({{(IN_W-OUT_W+1){1'b0}}, lim_i});
    lo = -hi;
    if (val_i > hi) begin
      sel = hi;
    end else if (val_i < lo) begin
      sel = lo;
    end else begin
      sel = val_i;
    end
    val_o = sel[OUT_W-1:0];
  end
endmodule

// File: rtl/pi_tune_ctrl.sv
module pi_tune_ctrl
  import pi_tune_pkg::*;
#(
  parameter int ERR_W  = DEF_ERR_W,
  parameter int GAIN_W = DEF_GAIN_W,
  parameter int WORD_W = DEF_WORD_W,
  parameter int ACC_W  = DEF_ACC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [ERR_W-1:0]  err_i,
  input  logic                     err_vld_i,
  input  logic signed [GAIN_W-1:0] kp_i,
  input  logic signed [GAIN_W-1:0] ki_i,
  input  logic signed [WORD_W-1:0] base_i,
  input  logic        [WORD_W-2:0] lim_i,
  output logic signed [WORD_W-1:0] tune_o,
  output logic                     upd_o
);
  localparam int PROD_W = ERR_W + GAIN_W;
  localparam int SUM_W  = ACC_W + 2;
  localparam int N_MUL  = 2;

  logic srst_n;

  logic signed [GAIN_W-1:0] gains [N_MUL];
  logic signed [PROD_W-1:0] prods [N_MUL];

  logic signed [ACC_W-1:0]  acc_inc;
  logic signed [ACC_W-1:0]  acc_nx;
  logic signed [SUM_W-1:0]  sum;
  logic signed [WORD_W-1:0] word_clip;
  logic signed [WORD_W-1:0] base_clip;

  logic signed [WORD_W-1:0] word_q, word_d;
  logic                     primed_q, primed_d;
  logic                     upd_q, upd_d;

  pi_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign gains[0] = kp_i;
  assign gains[1] = ki_i;

  for (genvar g = 0; g < N_MUL; g++) begin : g_mul
    pi_gain_mul #(.A_W(ERR_W), .B_W(GAIN_W)) u_mul (
      .a_i (err_i),
      .b_i (gains[g]),
      .p_o (prods[g])
    );
  end

  assign acc_inc = ACC_W'(prods[1]);

  pi_accum #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (srst_n),
    .en_i     (err_vld_i),
    .inc_i    (acc_inc),
    .acc_nx_o (acc_nx)
  );

  always_comb begin
    sum = SUM_W'(base_i) + SUM_W'(prods[0]) + SUM_W'(acc_nx);
  end

  pi_clip #(.IN_W(SUM_W), .OUT_W(WORD_W)) u_clip_sum (
    .val_i (sum),
    .lim_i (lim_i),
    .val_o (word_clip)
  );

  pi_clip #(.IN_W(WORD_W), .OUT_W(WORD_W)) u_clip_base (
    .val_i (base_i),
    .lim_i (lim_i),
    .val_o (base_clip)
  );

  always_comb begin
    word_d   = word_q;
    primed_d = primed_q;
    upd_d    = err_vld_i;
    if (err_vld_i) begin
      word_d   = word_clip;
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      word_q   <= '0;
      primed_q <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      word_q   <= word_d;
      primed_q <= primed_d;
      upd_q    <= upd_d;
    end
  end

  assign tune_o = primed_q ? word_q : base_clip;
  assign upd_o  = upd_q;
endmodule

// File: rtl/pi_tune_chk.sv
module pi_tune_chk #(
  parameter int WORD_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     err_vld_i,
  input logic        [WORD_W-2:0] lim_i,
  input logic signed [WORD_W-1:0] tune_o,
  input logic                     upd_o
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (upd_o) begin
      seen_q <= 1'b1;
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!upd_o);
    end
  end

  // R2
  upd_follows_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld_i |=> upd_o);

  // R2
  upd_only_after_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld_i |=> !upd_o);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !err_vld_i) |=> $stable(tune_o));

  // R6
  upper_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> ($signed({1'b0, tune_o}) <= $signed({2'b00, $past(lim_i)})
               || tune_o[WORD_W-1]));

  // R7
  lower_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> ($signed(tune_o) >= -$signed({2'b00, $past(lim_i)})));
endmodule

bind pi_tune_ctrl pi_tune_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_vld_i (err_vld_i),
  .lim_i     (lim_i),
  .tune_o    (tune_o),
  .upd_o     (upd_o)
);

// File: tb/pi_tune_ctrl_bench.sv
module pi_tune_ctrl_bench;
  localparam int ERR_W = 16;
  localparam int GAIN_W = 16;
  localparam int WORD_W = 24;
  localparam int NOM = 8161512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [ERR_W-1:0]  err_i = '0;
  logic                     err_vld_i = 1'b0;
  logic signed [GAIN_W-1:0] kp_i = '0;
  logic signed [GAIN_W-1:0] ki_i = '0;
  logic signed [WORD_W-1:0] base_i = '0;
  logic        [WORD_W-2:0] lim_i = '0;
  logic signed [WORD_W-1:0] tune_o;
  logic                     upd_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  longint acc_m = 0;

  always #10 clk = ~clk;

  pi_tune_ctrl u_pi_tune_ctrl (
    .clk(clk), .rst_n(rst_n), .err_i(err_i), .err_vld_i(err_vld_i),
    .kp_i(kp_i), .ki_i(ki_i), .base_i(base_i), .lim_i(lim_i),
    .tune_o(tune_o), .upd_o(upd_o)
  );

  localparam int TV_N = 8;
  localparam int TV_ERR [TV_N] = '{12, -40, 0, 500, -32768, 32767, 7, -1};
  localparam int TV_KP  [TV_N] = '{3, 3, 3, -7, 2, 5, -100, 1};
  localparam int TV_KI  [TV_N] = '{1, 1, 1, 2, -1, 0, -3, 1};

  function automatic longint clipv(longint v, longint l);
    if (v > l) return l;
    if (v < -l) return -l;
    return v;
  endfunction

  task automatic check(longint act, longint exp, string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    err_vld_i = 1'b0;
    repeat (2) @(negedge clk);
    check(longint'(upd_o), 0, "R1 upd during reset");
    check(longint'(tune_o), clipv(longint'(base_i), longint'(lim_i)), "R1 word during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    acc_m = 0;
  endtask

  task automatic event_chk(int e, string tag);
    longint exp;
    longint held;
    err_i = ERR_W'(e);
    err_vld_i = 1'b1;
    acc_m += longint'(e) * longint'(ki_i);
    exp = clipv(longint'(base_i) + longint'(e) * longint'(kp_i) + acc_m, longint'(lim_i));
    @(negedge clk);
    err_vld_i = 1'b0;
    check(longint'(upd_o), 1, {tag, " R2 strobe"});
    check(longint'(tune_o), exp, tag);
    held = longint'(tune_o);
    @(negedge clk);
    check(longint'(upd_o), 0, {tag, " R2 single pulse"});
    check(longint'(tune_o), held, {tag, " R5 hold"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint held;
    // R1: clipped base while idle after reset
    base_i = 24'sd1000;
    lim_i = 23'd500;
    do_reset();
    check(longint'(tune_o), 500, "R1 base clipped high");
    base_i = -24'sd1000;
    @(negedge clk);
    check(longint'(tune_o), -500, "R1 base clipped low");
    check(longint'(upd_o), 0, "R1 no strobe idle");

    // Table walk: R3 R4 R9
    base_i = 24'sd2000;
    lim_i = 23'(NOM);
    do_reset();
    check(longint'(tune_o), 2000, "R1 base after reset");
    for (int i = 0; i < TV_N; i++) begin
      kp_i = GAIN_W'(TV_KP[i]);
      ki_i = GAIN_W'(TV_KI[i]);
      event_chk(TV_ERR[i], $sformatf("R3 R4 R9 vector %0d", i));
    end

    // R5: inputs wiggle while strobe low
    held = longint'(tune_o);
    for (int k = 0; k < 5; k++) begin
      err_i = ERR_W'(1000 * (k + 1));
      kp_i = GAIN_W'(-50 * k);
      ki_i = GAIN_W'(77 * k);
      base_i = WORD_W'(-3000 * k);
      @(negedge clk);
      check(longint'(tune_o), held, "R5 idle word stable");
      check(longint'(upd_o), 0, "R5 idle no strobe");
    end
    base_i = 24'sd2000;
    kp_i = 16'sd3;
    ki_i = 16'sd1;
    event_chk(5, "R5 R4 accumulator untouched by idle");

    // R6 R7 at nominal limit
    base_i = '0;
    kp_i = 16'sd10000;
    ki_i = '0;
    do_reset();
    event_chk(1000, "R6 clip high");
    event_chk(-1000, "R7 clip low");

    // R8 exact boundaries
    lim_i = 23'd100;
    kp_i = 16'sd1;
    do_reset();
    event_chk(100, "R8 exact plus");
    event_chk(-100, "R8 exact minus");
    event_chk(101, "R6 one above");
    event_chk(-101, "R7 one below");

    // R10 windup
    kp_i = '0;
    ki_i = 16'sd100;
    do_reset();
    event_chk(10, "R10 wind 1");
    event_chk(10, "R10 wind 2");
    event_chk(10, "R10 wind 3");
    event_chk(-5, "R10 still clipped");
    check(acc_m, 2500, "R10 model accumulator");
    event_chk(-24, "R10 unwound");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule